// File: doc/BRIEF.md
# Near-Memory Transform Job Sequencer

This block is the control unit that sits next to one memory rank and runs radix-2 transform jobs on a local datapath. The host posts jobs as ordinary memory write data into a queue that holds two instructions. The block decodes each queued word into three fields: forward or inverse transform, an optional fused reference multiply, and the base-2 logarithm of the length. For each instruction it steps through every stage. While a stage runs it holds the datapath's mode selects and the buffer read and write enables. A stage ends once the datapath has reported the number of word pairs that the stage needs.

A job begins only when the host writes the start code into the memory-mapped status register. The block then runs the queued instructions in order and writes the end code into the same register when none remain. It also writes the end code when it meets an instruction with an illegal length. Instruction writes carry a rank field, which the block ignores, so one write on the shared channel loads every unit at once. When the host writes the idle code, the queue is emptied so that a new job can be loaded. When the host writes start again without first writing idle, the block runs the same queue a second time.

The controller has five states. IDLE waits for start. DECODE reads the current queue entry. RUN steps through the stages. NEXT advances the read pointer. FINISH writes the end code. The transitions are:
- IDLE→DECODE on start with a non-empty queue.
- IDLE→FINISH on start with an empty queue.
- DECODE→RUN for a legal length.
- DECODE→FINISH for an illegal length.
- RUN→NEXT after the last pair of the last stage.
- NEXT→DECODE while queued entries remain.
- NEXT→FINISH when no entries remain.
- FINISH→IDLE unconditionally.

Top module: `nmx_xform_seq`

## Requirements
- R1: After reset the status register reads 0 (idle), mode_sel is 000, iq_swap is low, stage_idx is 0, and both buffer enables are low.
- R2: An instruction word is taken from host_wdata bits 6:0. Bit 0 is the opcode (0 forward, 1 inverse). Bit 1 enables the reference multiply. Bits 6:2 hold log2 of the length L. The write is accepted whatever the value of host_wr_rank.
- R3: The queue keeps at most two instructions. A third write is dropped. An instruction write that arrives while the controller is not in IDLE is dropped.
- R4: No stage runs, and both buffer enables stay low, until the host writes 1 (start) into the status register.
- R5: An instruction runs L stages. stage_idx counts them 0..L-1. Each stage ends after max(2^L/4, 1) cycles in which pair_done is high while running.
- R6: While running, mode_sel is 000 for a plain forward transform, 001 for forward followed by reference multiply, 010 for a plain inverse, and 110 for reference multiply followed by inverse.
- R7: iq_swap is high only in the final stage of an inverse instruction, and only while running.
- R8: Queued instructions run in write order. Once the last one finishes, the status register reads 2 (end).
- R9: An instruction with L = 0 or L > 16 runs no stage. When decoding reaches it, the status register goes to 2 and any later queued instruction is skipped.
- R10: A host write of 0 to the status register empties the queue. A start written while the queue is empty sets status to 2 within three cycles. A start written again without the idle write runs the retained queue again.
- R11: buf_rd_en and buf_wr_en are both high in exactly the cycles in which a stage is running. A pair_done pulse outside those cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_instr_we | input | 1 | Host write to the instruction window |
| host_stat_we | input | 1 | Host write to the status register |
| host_wr_rank | input | RANK_W | Target rank of the host write (ignored) |
| host_wdata | input | DATA_W | Host write data |
| pair_done | input | 1 | Datapath has written one word pair |
| status | output | 2 | Status register: 0 idle, 1 start, 2 end |
| mode_sel | output | 3 | Datapath operation select |
| iq_swap | output | 1 | Output real/imaginary swap select |
| buf_rd_en | output | 1 | Data buffer read enable |
| buf_wr_en | output | 1 | Data buffer write enable |
| stage_idx | output | 5 | Current stage number |

## Verification
Some properties are checked by assertions on every cycle:
- the queue never holds more than two entries;
- mode_sel only takes the four legal codes;
- iq_swap is never high outside an enabled inverse;
- stage_idx stays below the decoded length and never moves by more than one between running cycles.

Other behaviour only the bench's scenarios can show:
- instructions run in queue order;
- the exact number of pair reports each stage consumes;
- iq_swap lands on the last stage;
- illegal lengths are rejected and the instructions behind them skipped;
- the idle write empties the queue and a repeated start reruns it;
- instruction writes during a run are dropped.

The bench checks these against a model of the queue built from the host writes it makes.

// File: rtl/nmx_pkg.sv
package nmx_pkg;
    localparam int LG_W    = 5;
    localparam int MAX_LG  = 16;
    localparam int INSTR_W = LG_W + 2;
    localparam int PAIR_W  = MAX_LG - 1;

    typedef enum logic [1:0] {
        STAT_IDLE = 2'd0,
        STAT_GO   = 2'd1,
        STAT_END  = 2'd2
    } stat_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_DECODE,
        F_RUN,
        F_NEXT,
        F_END
    } fsm_e;

    typedef struct packed {
        logic [LG_W-1:0] lg;
        logic            rm;
        logic            op;
    } instr_t;
endpackage

// File: rtl/nmx_instr_q.sv
module nmx_instr_q
    import nmx_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             clear,
    input  instr_t           wr_instr,
    input  logic [CNT_W-1:0] rd_idx,
    output instr_t           rd_instr,
    output logic [CNT_W-1:0] count
);
    instr_t slot_q [DEPTH];
    logic   full;

    assign full = (count == CNT_W'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (push && !full && count == CNT_W'(g))
                slot_q[g] <= wr_instr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (push && !full)
            count <= count + CNT_W'(1);
    end

    always_comb begin
        rd_instr = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == CNT_W'(i))
                rd_instr = slot_q[i];
    end

    // R3
    q_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/nmx_stage_ctr.sv
module nmx_stage_ctr #(
    parameter int LG_W   = 5,
    parameter int PAIR_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [LG_W-1:0] lg_in,
    input  logic            adv,
    output logic [LG_W-1:0] stage,
    output logic            last_stage,
    output logic            xfer_done
);
    logic [LG_W-1:0]   lg_q;
    logic [PAIR_W-1:0] pair_q;
    logic [PAIR_W-1:0] lim;
    logic              stage_end;

    assign lim = (lg_q >= LG_W'(2))
               ? ((PAIR_W'(1) << (lg_q - LG_W'(2))) - PAIR_W'(1))
               : '0;
    assign last_stage = (stage == lg_q - LG_W'(1));
    assign stage_end  = adv && (pair_q == lim);
    assign xfer_done  = stage_end && last_stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q   <= '0;
            stage  <= '0;
            pair_q <= '0;
        end else if (load) begin
            lg_q   <= lg_in;
            stage  <= '0;
            pair_q <= '0;
        end else if (stage_end) begin
            pair_q <= '0;
            if (!last_stage)
                stage <= stage + LG_W'(1);
        end else if (adv) begin
            pair_q <= pair_q + PAIR_W'(1);
        end
    end

    // R5
    stage_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_q != '0) |-> (stage < lg_q));
endmodule

// File: rtl/nmx_mode_gen.sv
module nmx_mode_gen (
    input  logic       running,
    input  logic       op_inv,
    input  logic       rm_en,
    input  logic       last_stage,
    output logic [2:0] mode_sel,
    output logic       iq_swap,
    output logic       rd_en,
    output logic       wr_en
);
    always_comb begin
        mode_sel = 3'b000;
        if (running) begin
            unique case ({op_inv, rm_en})
                2'b00: mode_sel = 3'b000;
                2'b01: mode_sel = 3'b001;
                2'b10: mode_sel = 3'b010;
                2'b11: mode_sel = 3'b110;
                default: mode_sel = 3'b000;
            endcase
        end
        iq_swap = running && op_inv && last_stage;
        rd_en   = running;
        wr_en   = running;
    end
endmodule

// File: rtl/nmx_xform_seq.sv
module nmx_xform_seq
    import nmx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int RANK_W = 2,
    parameter int QDEPTH = 2,
    localparam int QCNT_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_instr_we,
    input  logic              host_stat_we,
    input  logic [RANK_W-1:0] host_wr_rank,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              pair_done,
    output logic [1:0]        status,
    output logic [2:0]        mode_sel,
    output logic              iq_swap,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [LG_W-1:0]   stage_idx
);
    fsm_e              st_q, st_n;
    stat_e             stat_q;
    logic [QCNT_W-1:0] rd_ptr_q, q_count;
    instr_t            q_rd, instr_in;
    logic              cur_op_q, cur_rm_q;
    logic              q_push, q_clear, dec_ok, ld, running, adv;
    logic              last_stage, xfer_done;
    logic              unused_rank, unused_hi;

    // Rank and upper data bits carry nothing for this unit: broadcast accept.
    assign unused_rank = ^host_wr_rank;
    assign unused_hi   = ^host_wdata[DATA_W-1:INSTR_W];

    assign instr_in = instr_t'(host_wdata[INSTR_W-1:0]);
    assign q_push   = host_instr_we && (st_q == F_IDLE);
    assign q_clear  = host_stat_we && (host_wdata[1:0] == STAT_IDLE);
    assign dec_ok   = (q_rd.lg != '0) && (q_rd.lg <= LG_W'(MAX_LG));
    assign running  = (st_q == F_RUN);
    assign adv      = running && pair_done;
    assign status   = stat_q;

    nmx_instr_q #(.DEPTH(QDEPTH)) i_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .clear    (q_clear),
        .wr_instr (instr_in),
        .rd_idx   (rd_ptr_q),
        .rd_instr (q_rd),
        .count    (q_count)
    );

    nmx_stage_ctr #(.LG_W(LG_W), .PAIR_W(PAIR_W)) i_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld),
        .lg_in      (q_rd.lg),
        .adv        (adv),
        .stage      (stage_idx),
        .last_stage (last_stage),
        .xfer_done  (xfer_done)
    );

    nmx_mode_gen i_mode (
        .running    (running),
        .op_inv     (cur_op_q),
        .rm_en      (cur_rm_q),
        .last_stage (last_stage),
        .mode_sel   (mode_sel),
        .iq_swap    (iq_swap),
        .rd_en      (buf_rd_en),
        .wr_en      (buf_wr_en)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_n;
    end

    // Next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            F_IDLE:   if (stat_q == STAT_GO)
                          st_n = (q_count == '0) ? F_END : F_DECODE;
            F_DECODE: st_n = dec_ok ? F_RUN : F_END;
            F_RUN:    if (xfer_done) st_n = F_NEXT;
            F_NEXT:   st_n = ((rd_ptr_q + QCNT_W'(1)) < q_count) ? F_DECODE : F_END;
            F_END:    st_n = F_IDLE;
            default:  st_n = F_IDLE;
        endcase
    end

    // Per-state control outputs
    always_comb begin
        ld = (st_q == F_DECODE) && dec_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            cur_op_q <= 1'b0;
            cur_rm_q <= 1'b0;
        end else begin
            if (st_q == F_IDLE)      rd_ptr_q <= '0;
            else if (st_q == F_NEXT) rd_ptr_q <= rd_ptr_q + QCNT_W'(1);
            if (ld) begin
                cur_op_q <= q_rd.op;
                cur_rm_q <= q_rd.rm;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_q <= STAT_IDLE;
        else if (host_stat_we && host_wdata[1:0] != 2'd3)
            stat_q <= stat_e'(host_wdata[1:0]);
        else if (st_q == F_END)
            stat_q <= STAT_END;
    end

    // R6
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b000 || mode_sel == 3'b001 ||
         mode_sel == 3'b010 || mode_sel == 3'b110));

    // R7
    iq_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_swap |-> (mode_sel[1] && buf_wr_en));

    // R5
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr_en && $past(buf_wr_en)) |->
        (stage_idx == $past(stage_idx) || stage_idx == $past(stage_idx) + 1));
endmodule

// File: tb/test_nmx_xform_seq.sv
module test_nmx_xform_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 64;
    localparam int RANK_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_instr_we = 1'b0, host_stat_we = 1'b0, pair_done = 1'b0;
    logic [RANK_W-1:0] host_wr_rank = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [1:0] status;
    logic [2:0] mode_sel;
    logic iq_swap, buf_rd_en, buf_wr_en;
    logic [4:0] stage_idx;

    int n_chk = 0, n_fail = 0;
    int q_op[2], q_rm[2], q_lg[2];
    int qn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmx_xform_seq #(.DATA_W(DATA_W), .RANK_W(RANK_W)) i_nmx_xform_seq (
        .clk(clk), .rst_n(rst_n), .host_instr_we(host_instr_we),
        .host_stat_we(host_stat_we), .host_wr_rank(host_wr_rank),
        .host_wdata(host_wdata), .pair_done(pair_done), .status(status),
        .mode_sel(mode_sel), .iq_swap(iq_swap), .buf_rd_en(buf_rd_en),
        .buf_wr_en(buf_wr_en), .stage_idx(stage_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_mode(int op, int rm);
        if (op != 0) return (rm != 0) ? 6 : 2;
        return (rm != 0) ? 1 : 0;
    endfunction

    function automatic int ppairs(int lg);
        return (lg >= 2) ? (1 << (lg - 2)) : 1;
    endfunction

    task automatic wr_instr(input int op, input int rm, input int lg, input int rank);
        @(negedge clk);
        host_instr_we = 1'b1;
        host_wr_rank  = RANK_W'(rank);
        host_wdata    = {$urandom, 32'(((lg & 31) << 2) | ((rm & 1) << 1) | (op & 1))};
        @(negedge clk);
        host_instr_we = 1'b0;
        if (qn < 2) begin
            q_op[qn] = op; q_rm[qn] = rm; q_lg[qn] = lg; qn++;
        end
    endtask

    task automatic wr_stat(input int v);
        @(negedge clk);
        host_stat_we = 1'b1;
        host_wdata   = 64'(v);
        @(negedge clk);
        host_stat_we = 1'b0;
        if (v == 0) qn = 0;
    endtask

    task automatic run_job(input string tag, input bit inject);
        int n_exp, j, k, cyc;
        bit pd;
        n_exp = 0;
        for (int i = 0; i < qn; i++) begin
            if (q_lg[i] < 1 || q_lg[i] > 16) break;
            n_exp++;
        end
        j = 0; k = 0; cyc = 0;
        wr_stat(1);
        while (status != 2'd2 && cyc < 20000) begin
            if (buf_wr_en) begin
                if (j >= n_exp) chk(1'b0, "R8", {tag, " extra running cycle"}, j, n_exp);
                else begin
                    int es;
                    es = k / ppairs(q_lg[j]);
                    chk(int'(stage_idx) == es, "R5", {tag, " stage_idx"}, stage_idx, es);
                    chk(int'(mode_sel) == exp_mode(q_op[j], q_rm[j]), "R6",
                        {tag, " mode_sel"}, mode_sel, exp_mode(q_op[j], q_rm[j]));
                    chk(iq_swap == (q_op[j] != 0 && es == q_lg[j] - 1), "R7",
                        {tag, " iq_swap"}, iq_swap, int'(q_op[j] != 0 && es == q_lg[j] - 1));
                    chk(buf_rd_en == 1'b1, "R11", {tag, " rd_en while running"}, buf_rd_en, 1);
                end
            end else begin
                chk(!buf_rd_en && !iq_swap, "R11", {tag, " idle enables"},
                    int'(buf_rd_en | iq_swap), 0);
            end
            pd = ($urandom % 4) != 0;
            pair_done = pd;
            host_instr_we = inject && (cyc == 4);
            if (host_instr_we) host_wdata = 64'((3 << 2) | 1);
            if (buf_wr_en && pd && j < n_exp) begin
                k++;
                if (k == q_lg[j] * ppairs(q_lg[j])) begin j++; k = 0; end
            end
            @(negedge clk);
            cyc++;
        end
        host_instr_we = 1'b0;
        pair_done = 1'b0;
        chk(status == 2'd2, "R8", {tag, " end status"}, status, 2);
        chk(j == n_exp && k == 0, "R8", {tag, " instructions completed"}, j, n_exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 2'd0, "R1", "status", status, 0);
        chk(mode_sel == 3'd0 && !iq_swap, "R1", "mode/iq", int'(mode_sel), 0);
        chk(!buf_rd_en && !buf_wr_en, "R1", "enables", int'(buf_wr_en), 0);
        chk(stage_idx == 5'd0, "R1", "stage_idx", stage_idx, 0);

        // R2 fields and rank ignored; R4 nothing before start
        wr_instr(0, 0, 1, 0);
        wr_instr(1, 1, 4, 3);
        begin
            int seen;
            seen = 0;
            for (int c = 0; c < 20; c++) begin
                pair_done = 1'b1;
                @(negedge clk);
                if (buf_wr_en) seen++;
            end
            pair_done = 1'b0;
            chk(seen == 0 && status == 2'd0, "R4", "run before start", seen, 0);
        end
        run_job("R2 directed", 1'b0);

        // R3 third write dropped
        wr_stat(0);
        wr_instr(0, 1, 3, 1);
        wr_instr(1, 0, 2, 2);
        wr_instr(1, 1, 5, 0);
        run_job("R3 overflow", 1'b0);

        // R9 illegal length first, then illegal length second
        wr_stat(0);
        wr_instr(0, 0, 0, 0);
        wr_instr(1, 0, 3, 0);
        run_job("R9 lg0 first", 1'b0);
        wr_stat(0);
        wr_instr(1, 1, 3, 2);
        wr_instr(0, 0, 17, 1);
        run_job("R9 lg17 second", 1'b0);

        // R10 idle write empties the queue
        wr_stat(0);
        wr_instr(1, 1, 6, 0);
        wr_stat(0);
        wr_instr(0, 1, 2, 3);
        run_job("R10 clear", 1'b0);

        // R3 write during run dropped; R10 rerun of retained queue
        wr_stat(0);
        wr_instr(1, 0, 3, 1);
        run_job("R3 write during run", 1'b1);
        run_job("R10 rerun", 1'b0);

        // R10 empty queue start
        wr_stat(0);
        wr_stat(1);
        begin
            int w;
            bit ran;
            w = 0; ran = 0;
            while (status != 2'd2 && w < 10) begin
                if (buf_wr_en) ran = 1;
                @(negedge clk);
                w++;
            end
            chk(w <= 3 && !ran, "R10", "empty start end latency", w, 2);
        end

        // Random jobs (R2 R5 R6 R7 R8)
        for (int t = 0; t < 6; t++) begin
            int n;
            wr_stat(0);
            n = 1 + ($urandom % 2);
            for (int i = 0; i < n; i++)
                wr_instr($urandom % 2, $urandom % 2, 1 + ($urandom % 9), $urandom % 4);
            run_job("random", 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule